// File: doc/BRIEF.md
# Interrupt Entry and Vector Unit

This unit performs the state changes a processor makes when it enters an interrupt handler. It covers two interrupt classes: a storage fault raised while fetching an instruction, and a level-sensitive external input. It picks which class to take and forms the handler fetch address. It also produces the values for the architectural registers that the surrounding core owns: the return address, the saved copy of the machine state, the new machine state and the exception syndrome.

The fetch-fault request arrives on a valid/ready pair. A fault with `flt_valid` high is accepted on a clock edge where `flt_ready` is also high. The source must hold the fault and its payload steady until that happens. The external input has no ready signal. It is a level that must stay high until the unit answers with the one-cycle `ext_ack` pulse. If it drops before that, it may never be taken. The entry outputs are a single-cycle result, valid while `entry_valid` is high. They cannot be back-pressured, so the owner of the architectural registers must write them in that cycle.

`flt_ready` is low for one cycle after each entry. During that cycle the owner is committing the new machine state. No request is taken in that cycle, which prevents a second entry based on a stale state value.

Top module: `ie_entry_unit`

## Requirements
- R1: The handler address is the 16-bit `vec_base`, then the 12-bit offset of the class being taken, then four zero bits in [3:0]. The fetch fault uses `off_fetch` and the external input uses `off_ext`.
- R2: For an external entry with `ext_vec_sel` = 1, the 12-bit `ext_off_in` replaces `off_ext` in bits [15:4] of the handler address.
- R3: An external request is taken only while bit 15 (external enable) of `cur_state` is 1. While that bit is 0, the request gives no entry and no `ext_ack`, and it is taken once the bit becomes 1.
- R4: When a fault and an external request are both present in the same cycle, the fault is taken and `ext_ack` stays low. The external request is taken later if it is still held.
- R5: `save_state` equals `cur_state` as it was in the cycle the entry was taken.
- R6: `state_next` equals `cur_state` with bits 26, 25, 18, 15, 14, 13, 11, 8, 5 and 4 forced to 0. Every other bit is carried through unchanged, including 17, 12, 9 and 1.
- R7: On a fault entry, `save_pc` equals `flt_pc` and `synd_we` is 1. `synd_next` holds `flt_cause[3:0]` in bits [11:8] and zero in every other bit.
- R8: On an external entry, `save_pc` equals `next_pc` and `synd_we` is 0, so the syndrome register keeps its value.
- R9: Entry outputs are valid in the cycle after the request is taken. `entry_valid` lasts one cycle. `entry_class` is 0 for a fault and 1 for an external entry. `ext_ack` is high exactly on external entries.
- R10: `flt_ready` is 0 in every cycle where `entry_valid` is 1. A fault held through that cycle is taken on the next edge.
- R11: During and after reset, `entry_valid` and `ext_ack` are 0 and `flt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fetch-fault request valid |
| flt_ready | output | 1 | Unit can accept a fault this cycle |
| flt_pc | input | 32 | Address of the faulting instruction |
| flt_cause | input | 4 | Fault cause bits for the syndrome |
| ext_req | input | 1 | Level-sensitive external interrupt request |
| ext_ack | output | 1 | One-cycle acknowledge of the external request |
| ext_vec_sel | input | 1 | 1: take the external offset from `ext_off_in` |
| ext_off_in | input | 12 | Externally supplied handler offset |
| next_pc | input | 32 | Address of the instruction that would run next |
| cur_state | input | 32 | Current machine state |
| vec_base | input | 16 | Handler address prefix |
| off_fetch | input | 12 | Handler offset for the fetch fault |
| off_ext | input | 12 | Handler offset for the external input |
| entry_valid | output | 1 | Entry outputs valid this cycle |
| entry_class | output | 1 | 0 fetch fault, 1 external input |
| handler_addr | output | 32 | Handler fetch address |
| save_pc | output | 32 | Return address to save |
| save_state | output | 32 | Machine state to save |
| state_next | output | 32 | New machine state |
| synd_we | output | 1 | Write enable for the syndrome register |
| synd_next | output | 32 | New syndrome value |

## Verification
The bench sweeps every fault cause value and several state, prefix and offset patterns, and checks the clear mask bit by bit. A mask with a wrong position would clear a bit that should be kept, or keep one that should be cleared. It drives both request types in the same cycle: a priority error shows up as an acknowledge on a fault entry or as a lost fault. It holds an external request while the enable bit is clear, which catches a unit that ignores the enable. It presents a fault during the hold-off cycle, which catches a unit that takes an entry from stale state or drops the held fault. Both offset sources are also swept, and a broken offset select would put the wrong value in bits [15:4] of the handler address.

// File: rtl/ie_pkg.sv
package ie_pkg;
  localparam int ST_W = 32;

  // machine-state bit positions
  localparam int B_LOCK_CLR  = 26;
  localparam int B_VEC_EN    = 25;
  localparam int B_WAIT_EN   = 18;
  localparam int B_EXT_EN    = 15;
  localparam int B_USER      = 14;
  localparam int B_FPU_EN    = 13;
  localparam int B_FPX0      = 11;
  localparam int B_FPX1      = 8;
  localparam int B_ISPACE    = 5;
  localparam int B_DSPACE    = 4;

  localparam logic [ST_W-1:0] ST_CLEAR =
      (ST_W'(1) << B_LOCK_CLR) | (ST_W'(1) << B_VEC_EN) |
      (ST_W'(1) << B_WAIT_EN)  | (ST_W'(1) << B_EXT_EN) |
      (ST_W'(1) << B_USER)     | (ST_W'(1) << B_FPU_EN) |
      (ST_W'(1) << B_FPX0)     | (ST_W'(1) << B_FPX1)   |
      (ST_W'(1) << B_ISPACE)   | (ST_W'(1) << B_DSPACE);

  typedef enum logic { CLS_FETCH = 1'b0, CLS_EXT = 1'b1 } ie_class_e;
endpackage

// File: rtl/ie_arbiter.sv
module ie_arbiter (
  input  logic flt_valid,
  input  logic ext_req,
  input  logic ext_en,
  input  logic holdoff,
  output logic flt_ready,
  output logic take_flt,
  output logic take_ext
);
  always_comb begin
    flt_ready = !holdoff;
    take_flt  = flt_valid && !holdoff;
    // fault has priority; external waits while enable is clear
    take_ext  = ext_req && ext_en && !holdoff && !flt_valid;
  end
endmodule

// File: rtl/ie_vector.sv
module ie_vector #(
  parameter int BASE_W  = 16,
  parameter int OFF_W   = 12,
  parameter int ALIGN_W = 4,
  localparam int HA_W   = BASE_W + OFF_W + ALIGN_W
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  off_fetch,
  input  logic [OFF_W-1:0]  off_ext,
  input  logic [OFF_W-1:0]  ext_off_in,
  input  logic              ext_vec_sel,
  input  logic              sel_ext,
  output logic [HA_W-1:0]   addr
);
  logic [OFF_W-1:0] off;

  always_comb begin
    if (!sel_ext)         off = off_fetch;
    else if (ext_vec_sel) off = ext_off_in;
    else                  off = off_ext;
  end

  generate
    if (ALIGN_W > 0) begin : g_align
      assign addr = {base, off, {ALIGN_W{1'b0}}};
    end else begin : g_noalign
      assign addr = {base, off};
    end
  endgenerate
endmodule

// File: rtl/ie_state_mask.sv
module ie_state_mask
  import ie_pkg::*;
(
  input  logic [ST_W-1:0] st_in,
  output logic [ST_W-1:0] st_out
);
  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (ST_CLEAR[i]) begin : g_clr
        assign st_out[i] = 1'b0;
      end else begin : g_keep
        assign st_out[i] = st_in[i];
      end
    end
  endgenerate
endmodule

// File: rtl/ie_syndrome.sv
module ie_syndrome #(
  parameter int SYND_W    = 32,
  parameter int CAUSE_W   = 4,
  parameter int CAUSE_LSB = 8
) (
  input  logic [CAUSE_W-1:0] cause,
  output logic [SYND_W-1:0]  synd
);
  generate
    for (genvar i = 0; i < SYND_W; i++) begin : g_bit
      if (i >= CAUSE_LSB && i < CAUSE_LSB + CAUSE_W) begin : g_cause
        assign synd[i] = cause[i-CAUSE_LSB];
      end else begin : g_zero
        assign synd[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ie_entry_unit.sv
module ie_entry_unit
  import ie_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_W    = 16,
  parameter int OFF_W     = 12,
  parameter int ALIGN_W   = 4,
  parameter int CAUSE_W   = 4,
  parameter int CAUSE_LSB = 8,
  parameter int SYND_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flt_valid,
  output logic                          flt_ready,
  input  logic [ADDR_W-1:0]             flt_pc,
  input  logic [CAUSE_W-1:0]            flt_cause,
  input  logic                          ext_req,
  output logic                          ext_ack,
  input  logic                          ext_vec_sel,
  input  logic [OFF_W-1:0]              ext_off_in,
  input  logic [ADDR_W-1:0]             next_pc,
  input  logic [ST_W-1:0]               cur_state,
  input  logic [BASE_W-1:0]             vec_base,
  input  logic [OFF_W-1:0]              off_fetch,
  input  logic [OFF_W-1:0]              off_ext,
  output logic                          entry_valid,
  output logic                          entry_class,
  output logic [BASE_W+OFF_W+ALIGN_W-1:0] handler_addr,
  output logic [ADDR_W-1:0]             save_pc,
  output logic [ST_W-1:0]               save_state,
  output logic [ST_W-1:0]               state_next,
  output logic                          synd_we,
  output logic [SYND_W-1:0]             synd_next
);
  localparam int HA_W = BASE_W + OFF_W + ALIGN_W;

  logic              take_flt, take_ext, take_any;
  logic [HA_W-1:0]   addr_c;
  logic [ST_W-1:0]   masked_c;
  logic [SYND_W-1:0] synd_c;

  ie_arbiter u_arb (
    .flt_valid (flt_valid),
    .ext_req   (ext_req),
    .ext_en    (cur_state[B_EXT_EN]),
    .holdoff   (entry_valid),
    .flt_ready (flt_ready),
    .take_flt  (take_flt),
    .take_ext  (take_ext)
  );

  ie_vector #(.BASE_W(BASE_W), .OFF_W(OFF_W), .ALIGN_W(ALIGN_W)) u_vec (
    .base        (vec_base),
    .off_fetch   (off_fetch),
    .off_ext     (off_ext),
    .ext_off_in  (ext_off_in),
    .ext_vec_sel (ext_vec_sel),
    .sel_ext     (take_ext),
    .addr        (addr_c)
  );

  ie_state_mask u_mask (
    .st_in  (cur_state),
    .st_out (masked_c)
  );

  ie_syndrome #(.SYND_W(SYND_W), .CAUSE_W(CAUSE_W), .CAUSE_LSB(CAUSE_LSB)) u_synd (
    .cause (flt_cause),
    .synd  (synd_c)
  );

  assign take_any = take_flt || take_ext;

  // control outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      ext_ack     <= 1'b0;
      synd_we     <= 1'b0;
      entry_class <= CLS_FETCH;
    end else begin
      entry_valid <= take_any;
      ext_ack     <= take_ext;
      synd_we     <= take_flt;
      if (take_any) entry_class <= take_ext ? CLS_EXT : CLS_FETCH;
    end
  end

  // data outputs, loaded only when an entry is taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handler_addr <= '0;
      save_pc      <= '0;
      save_state   <= '0;
      state_next   <= '0;
      synd_next    <= '0;
    end else if (take_any) begin
      handler_addr <= addr_c;
      save_pc      <= take_ext ? next_pc : flt_pc;
      save_state   <= cur_state;
      state_next   <= masked_c;
      synd_next    <= synd_c;
    end
  end
endmodule

// File: rtl/ie_entry_chk.sv
module ie_entry_chk
  import ie_pkg::*;
#(
  parameter int HA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flt_valid,
  input logic            flt_ready,
  input logic            ext_ack,
  input logic            entry_valid,
  input logic            entry_class,
  input logic [HA_W-1:0] handler_addr,
  input logic [ST_W-1:0] cur_state,
  input logic [ST_W-1:0] save_state,
  input logic [ST_W-1:0] state_next,
  input logic            synd_we
);
  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> handler_addr[3:0] == 4'b0);
  // R3
  ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> $past(cur_state[B_EXT_EN]));
  // R4
  fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready) |=> (entry_valid && !entry_class && !ext_ack));
  // R5
  saved_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> save_state == $past(cur_state));
  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> ((state_next & ~save_state) == '0 && !state_next[B_EXT_EN]));
  // R7
  fault_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && !entry_class) |-> synd_we);
  // R8
  ext_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_class) |-> !synd_we);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |=> !entry_valid);
  // R9
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack == (entry_valid && entry_class));
  // R10
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> !flt_ready);
endmodule

bind ie_entry_unit ie_entry_chk #(.HA_W(BASE_W + OFF_W + ALIGN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flt_valid    (flt_valid),
  .flt_ready    (flt_ready),
  .ext_ack      (ext_ack),
  .entry_valid  (entry_valid),
  .entry_class  (entry_class),
  .handler_addr (handler_addr),
  .cur_state    (cur_state),
  .save_state   (save_state),
  .state_next   (state_next),
  .synd_we      (synd_we)
);

// File: tb/ie_entry_unit_tb.sv
module ie_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flt_valid, flt_ready;
  logic [31:0] flt_pc;
  logic [3:0]  flt_cause;
  logic        ext_req, ext_ack, ext_vec_sel;
  logic [11:0] ext_off_in;
  logic [31:0] next_pc, cur_state;
  logic [15:0] vec_base;
  logic [11:0] off_fetch, off_ext;
  logic        entry_valid, entry_class;
  logic [31:0] handler_addr, save_pc, save_state, state_next;
  logic        synd_we;
  logic [31:0] synd_next;

  int n_chk = 0;
  int n_bad = 0;
  localparam logic [31:0] CLR = 32'h0604_E930;
  localparam logic [31:0] EXT_EN = 32'h0000_8000;

  always #2.5 clk = ~clk;

  ie_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_pc(flt_pc), .flt_cause(flt_cause),
    .ext_req(ext_req), .ext_ack(ext_ack), .ext_vec_sel(ext_vec_sel), .ext_off_in(ext_off_in),
    .next_pc(next_pc), .cur_state(cur_state), .vec_base(vec_base),
    .off_fetch(off_fetch), .off_ext(off_ext),
    .entry_valid(entry_valid), .entry_class(entry_class), .handler_addr(handler_addr),
    .save_pc(save_pc), .save_state(save_state), .state_next(state_next),
    .synd_we(synd_we), .synd_next(synd_next)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic fire_fault(input logic [31:0] pc, input logic [3:0] cause,
                            input logic [31:0] st, input logic [15:0] base,
                            input logic [11:0] off);
    flt_valid = 1'b1; flt_pc = pc; flt_cause = cause;
    cur_state = st; vec_base = base; off_fetch = off;
    chk("R10", "ready before fault", 32'(flt_ready), 1);
    next_cyc();
    flt_valid = 1'b0;
    chk("R9", "fault entry_valid", 32'(entry_valid), 1);
    chk("R9", "fault class", 32'(entry_class), 0);
    chk("R1", "fault handler", handler_addr, {base, off, 4'b0});
    chk("R7", "fault save_pc", save_pc, pc);
    chk("R5", "fault save_state", save_state, st);
    chk("R6", "fault state_next", state_next, st & ~CLR);
    chk("R7", "fault synd_we", 32'(synd_we), 1);
    chk("R7", "fault synd", synd_next, 32'(cause) << 8);
    chk("R9", "fault no ack", 32'(ext_ack), 0);
    chk("R10", "ready low in entry cycle", 32'(flt_ready), 0);
    next_cyc();
    chk("R9", "pulse one cycle", 32'(entry_valid), 0);
  endtask

  task automatic fire_ext(input logic [31:0] npc, input logic [31:0] st,
                          input logic [15:0] base, input logic [11:0] off,
                          input logic sel, input logic [11:0] xoff);
    ext_req = 1'b1; next_pc = npc; cur_state = st | EXT_EN;
    vec_base = base; off_ext = off; ext_vec_sel = sel; ext_off_in = xoff;
    next_cyc();
    ext_req = 1'b0;
    chk("R9", "ext entry_valid", 32'(entry_valid), 1);
    chk("R9", "ext class", 32'(entry_class), 1);
    chk("R9", "ext ack", 32'(ext_ack), 1);
    chk(sel ? "R2" : "R1", "ext handler", handler_addr, {base, sel ? xoff : off, 4'b0});
    chk("R8", "ext save_pc", save_pc, npc);
    chk("R5", "ext save_state", save_state, st | EXT_EN);
    chk("R6", "ext state_next", state_next, (st | EXT_EN) & ~CLR);
    chk("R8", "ext synd_we", 32'(synd_we), 0);
    next_cyc();
    chk("R9", "ack one cycle", 32'(ext_ack), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt_valid = 1'b0; ext_req = 1'b0; ext_vec_sel = 1'b0;
    flt_pc = '0; flt_cause = '0; ext_off_in = '0; next_pc = '0;
    cur_state = '0; vec_base = '0; off_fetch = '0; off_ext = '0;
    repeat (3) next_cyc();
    chk("R11", "reset entry_valid", 32'(entry_valid), 0);
    chk("R11", "reset ack", 32'(ext_ack), 0);
    chk("R11", "reset ready", 32'(flt_ready), 1);
    rst_n = 1'b1;
    next_cyc();
    chk("R11", "post-reset ready", 32'(flt_ready), 1);

    // R7 R6: every cause value, varied state and vector fields
    for (int c = 0; c < 16; c++) begin
      fire_fault(32'h1000_0000 + 32'(c) * 32'h44, 4'(c),
                 32'hFFFF_FFFF ^ (32'(c) * 32'h1111_1111),
                 16'(c * 16'h1357), 12'(c * 12'h0AB));
    end
    // R6: single-bit states, clear vs keep per position
    for (int b = 0; b < 32; b++) begin
      fire_fault(32'h2000_0000, 4'hA, 32'(1) << b, 16'hBEEF, 12'h123);
    end

    // R1 R2 R8: both offset sources
    for (int k = 0; k < 8; k++) begin
      fire_ext(32'h3000_0000 + 32'(k) * 4, 32'hA5A5_0000 ^ (32'(k) << 3),
               16'(k * 16'h2468), 12'(k * 12'h111), k[0], 12'hFFF - 12'(k * 12'h0F0));
    end

    // R3: request held while enable is clear
    ext_req = 1'b1; cur_state = 32'hFFFF_7FFF; next_pc = 32'h4000_0000;
    vec_base = 16'h0F0F; off_ext = 12'h345; ext_vec_sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      next_cyc();
      chk("R3", "no entry while disabled", 32'(entry_valid), 0);
      chk("R3", "no ack while disabled", 32'(ext_ack), 0);
    end
    cur_state = 32'hFFFF_FFFF;
    next_cyc();
    ext_req = 1'b0;
    chk("R3", "taken once enabled", 32'(ext_ack), 1);
    chk("R3", "handler once enabled", handler_addr, {16'h0F0F, 12'h345, 4'b0});
    next_cyc();

    // R4: both at once
    flt_valid = 1'b1; ext_req = 1'b1; flt_pc = 32'h5000_0000; flt_cause = 4'h5;
    cur_state = EXT_EN; next_pc = 32'h5000_0004;
    next_cyc();
    flt_valid = 1'b0;
    chk("R4", "fault class wins", 32'(entry_class), 0);
    chk("R4", "no ack on fault win", 32'(ext_ack), 0);
    chk("R4", "fault pc", save_pc, 32'h5000_0000);
    next_cyc();
    chk("R10", "no entry in holdoff", 32'(entry_valid), 0);
    next_cyc();
    ext_req = 1'b0;
    chk("R4", "external later", 32'(ext_ack), 1);
    chk("R4", "external pc", save_pc, 32'h5000_0004);

    // R10: fault arriving in the hold-off cycle waits one cycle
    flt_valid = 1'b1; flt_pc = 32'h6000_0000; flt_cause = 4'h3;
    chk("R10", "ready low during holdoff", 32'(flt_ready), 0);
    next_cyc();
    chk("R10", "not taken in holdoff", 32'(entry_valid), 0);
    next_cyc();
    flt_valid = 1'b0;
    chk("R10", "held fault taken", 32'(entry_valid), 1);
    chk("R10", "held fault pc", save_pc, 32'h6000_0000);
    chk("R7", "held fault synd", synd_next, 32'h0000_0300);
    next_cyc();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule